// File: doc/BRIEF.md
# Daisy-Chain Address Enumeration Sequencer

This block runs on the master side of a daisy-chained peripheral bus and hands out bus addresses one peripheral at a time. A peripheral that has no address yet keeps its downstream bus switch open. An assignment command sent to the unassigned address zero therefore lands only on the first peripheral still waiting. Once addressed, that peripheral closes its switch, and the next command reaches the one behind it. Each frame the sequencer requests carries the assignment of the next address, so it is sent in long-word format.

A peripheral confirms its new address exactly once, in the response slot of the frame that follows its assignment. The sequencer therefore pipelines the work. Frame k assigns address k, and the slot of frame k tells whether address k-1 was taken. The first slot after a start is ignored because there was no earlier frame. A missing confirmation means the chain has ended. The sequencer then raises its done flag, reports how many devices answered, and switches the frame format to short words. It also marks the response of the first short frame as one to discard, since that response belongs to a frame of a different size.

When every usable address is taken and the last one is still confirmed, the sequencer cannot tell whether more devices follow. In that case it stops in an error state. The transmit engine, the CRC and the physical bus are outside this block.

Top module: `chain_enum_seq`

## Requirements
- R1: After reset, frm_req_o, done_o, error_o and discard_o are 0, dev_count_o is 0 and frm_long_o is 1 (long-word format).
- R2: A start_i pulse while idle, done or in error begins a run: frame k of the run (k counted from 1) is an assignment frame (frm_assign_o=1) with frm_addr_o=k for every k up to 2**ADDR_W-1, and frm_long_o stays 1 throughout the run.
- R3: frm_req_o stays high, with its frame fields stable, until the cycle in which frm_ack_i is high. It drops in the following cycle, and no new request appears until the response slot of the accepted frame has ended (rsp_slot_i pulse).
- R4: The response slot of the first frame of a run is ignored whatever rsp_ok_i shows.
- R5: A response (rsp_ok_i=1 at the slot end) in frame k, k>=2, confirms address k-1. dev_count_o equals the number of confirmations, and a run with N devices (N below 2**ADDR_W-1) takes exactly N+2 frames.
- R6: A missing response in a checked slot ends the run: done_o=1, frm_long_o=0 (short-word format), no further requests, and done_o stays 1 until the next start.
- R7: discard_o rises together with done_o and falls after the first rsp_slot_i pulse seen while done.
- R8: The frame after the assignment of the top address 2**ADDR_W-1 is a non-assignment frame with frm_assign_o=0 and frm_addr_o=0. A response in its slot sets dev_count_o to the top address, raises error_o with done_o low, and stops requests.
- R9: start_i during a run has no effect on the frame sequence or the result.
- R10: rsp_slot_i pulses while no frame is in flight (request pending and not yet accepted) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an enumeration run (pulse) |
| frm_req_o | output | 1 | Frame request to the transmit engine |
| frm_ack_i | input | 1 | Transmit engine accepts the requested frame |
| frm_assign_o | output | 1 | Requested frame carries an address assignment |
| frm_addr_o | output | ADDR_W | New address carried by the frame, 0 when not an assignment |
| frm_long_o | output | 1 | 1 selects long-word frames, 0 short-word frames |
| rsp_slot_i | input | 1 | Response slot of the current frame has ended (pulse) |
| rsp_ok_i | input | 1 | A valid response was present in that slot |
| done_o | output | 1 | Enumeration ended at the end of the chain |
| error_o | output | 1 | Address space used up while devices still answered |
| dev_count_o | output | ADDR_W | Number of confirmed peripherals |
| discard_o | output | 1 | Response of the next short frame must be discarded |

## Verification
On every cycle the assertions check that a request is held until it is accepted and never overlaps a frame in flight, and that assignment frames never carry address zero. They also check that the confirmed count moves only by one step or back to zero, that the pending address leads the count by one, that done and error exclude each other, and that discard only appears with done in short format. The bench's chain model has to show the parts that depend on the device count: the one-frame-late confirmation, the exact number of frames per run, and the end of a run on the first missing response. It also has to show that the first slot, stray slot pulses and a second start during a run are ignored.

// File: rtl/chain_enum_pkg.sv
package chain_enum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_SEND_ASSIGN = 3'd1,
    ST_AWAIT_ACK   = 3'd2,
    ST_DONE        = 3'd3,
    ST_ERROR       = 3'd4
  } enum_state_t;

endpackage

// File: rtl/chain_enum_addr_ctr.sv
module chain_enum_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] pend_o,
  output logic [ADDR_W-1:0] count_o,
  output logic              pend_max_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pend_q;
  logic [ADDR_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pend_q  <= ADDR_ONE;
      count_q <= '0;
    end else if (step_i) begin
      count_q <= pend_q;
      if (pend_q != ADDR_TOP) begin
        pend_q <= pend_q + 1'b1;
      end
    end
  end

  assign pend_o     = pend_q;
  assign count_o    = count_q;
  assign pend_max_o = (pend_q == ADDR_TOP);

  AST_PEND_LEADS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (count_q != ADDR_TOP) |-> (pend_q == count_q + 1'b1)); // R5

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    !$stable(count_q) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0))); // R5

endmodule

// File: rtl/chain_enum_frame_port.sv
module chain_enum_frame_port #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              load_assign_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              ack_i,
  input  logic              slot_i,
  output logic              req_o,
  output logic              assign_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              slot_evt_o
);

  logic              req_q;
  logic              flight_q;
  logic              assign_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      flight_q <= 1'b0;
      assign_q <= 1'b0;
      addr_q   <= '0;
    end else if (load_i) begin
      req_q    <= 1'b1;
      flight_q <= 1'b0;
      assign_q <= load_assign_i;
      addr_q   <= load_addr_i;
    end else if (req_q && ack_i) begin
      req_q    <= 1'b0;
      flight_q <= 1'b1;
    end else if (flight_q && slot_i) begin
      flight_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign assign_o   = assign_q;
  assign addr_o     = addr_q;
  assign slot_evt_o = flight_q && slot_i;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i) |=> (req_q && $stable(addr_q) && $stable(assign_q))); // R3

  AST_REQ_NOT_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    !(req_q && flight_q)); // R3

  AST_ACK_STARTS_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (req_q && ack_i && !load_i) |=> (!req_q && flight_q)); // R3

  AST_ASSIGN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (req_q && assign_q) |-> (addr_q != '0)); // R2

endmodule

// File: rtl/chain_enum_seq.sv
module chain_enum_seq
  import chain_enum_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              frm_req_o,
  input  logic              frm_ack_i,
  output logic              frm_assign_o,
  output logic [ADDR_W-1:0] frm_addr_o,
  output logic              frm_long_o,
  input  logic              rsp_slot_i,
  input  logic              rsp_ok_i,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] dev_count_o,
  output logic              discard_o
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  enum_state_t       state_q;
  logic              done_q;
  logic              error_q;
  logic              long_q;
  logic              discard_q;

  logic              ctr_clr;
  logic              ctr_step;
  logic [ADDR_W-1:0] pend;
  logic [ADDR_W-1:0] count;
  logic              pend_max;
  logic [ADDR_W-1:0] nxt_pend;

  logic              ld;
  logic              ld_assign;
  logic [ADDR_W-1:0] ld_addr;
  logic              slot_evt;
  logic              can_start;

  assign can_start = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);
  assign nxt_pend  = pend + 1'b1;

  always_comb begin
    ctr_clr   = 1'b0;
    ctr_step  = 1'b0;
    ld        = 1'b0;
    ld_assign = 1'b0;
    ld_addr   = '0;
    unique case (state_q)
      ST_SEND_ASSIGN: begin
        if (slot_evt) begin
          ld        = 1'b1;
          ld_assign = (pend != ADDR_TOP);
          ld_addr   = ld_assign ? nxt_pend : '0;
        end
      end
      ST_AWAIT_ACK: begin
        if (slot_evt && rsp_ok_i) begin
          ctr_step = 1'b1;
          if (!pend_max) begin
            ld        = 1'b1;
            ld_assign = (nxt_pend != ADDR_TOP);
            ld_addr   = ld_assign ? (nxt_pend + 1'b1) : '0;
          end
        end
      end
      default: begin
        if (start_i) begin
          ctr_clr   = 1'b1;
          ld        = 1'b1;
          ld_assign = 1'b1;
          ld_addr   = ADDR_ONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
      long_q    <= 1'b1;
      discard_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEND_ASSIGN: begin
          if (slot_evt) state_q <= ST_AWAIT_ACK;
        end
        ST_AWAIT_ACK: begin
          if (slot_evt) begin
            if (!rsp_ok_i) begin
              state_q   <= ST_DONE;
              done_q    <= 1'b1;
              long_q    <= 1'b0;
              discard_q <= 1'b1;
            end else if (pend_max) begin
              state_q <= ST_ERROR;
              error_q <= 1'b1;
            end
          end
        end
        default: begin
          if (start_i) begin
            state_q   <= ST_SEND_ASSIGN;
            done_q    <= 1'b0;
            error_q   <= 1'b0;
            long_q    <= 1'b1;
            discard_q <= 1'b0;
          end else if (state_q == ST_DONE && rsp_slot_i) begin
            discard_q <= 1'b0;
          end
        end
      endcase
    end
  end

  chain_enum_addr_ctr #(.ADDR_W(ADDR_W)) i_addr_ctr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (ctr_clr),
    .step_i     (ctr_step),
    .pend_o     (pend),
    .count_o    (count),
    .pend_max_o (pend_max)
  );

  chain_enum_frame_port #(.ADDR_W(ADDR_W)) i_frame_port (
    .clk           (clk),
    .rst           (rst),
    .load_i        (ld),
    .load_assign_i (ld_assign),
    .load_addr_i   (ld_addr),
    .ack_i         (frm_ack_i),
    .slot_i        (rsp_slot_i),
    .req_o         (frm_req_o),
    .assign_o      (frm_assign_o),
    .addr_o        (frm_addr_o),
    .slot_evt_o    (slot_evt)
  );

  assign frm_long_o  = long_q;
  assign done_o      = done_q;
  assign error_o     = error_q;
  assign dev_count_o = count;
  assign discard_o   = discard_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_q && error_q)); // R8

  AST_DONE_SHORT: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!long_q && !frm_req_o)); // R6

  AST_DISCARD_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    discard_q |-> done_q); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_i) |=> done_q); // R6

  AST_BUSY_LONG: assert property (@(posedge clk) disable iff (rst)
    frm_req_o |-> long_q); // R2

  AST_ERR_TOP_COUNT: assert property (@(posedge clk) disable iff (rst)
    error_q |-> (count == ADDR_TOP)); // R8

endmodule

// File: tb/test_chain_enum_seq.sv
`timescale 1ns/1ps
module test_chain_enum_seq;

  localparam int ADDR_W = 4;
  localparam int TOP    = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              frm_req_o;
  logic              frm_ack_i = 1'b0;
  logic              frm_assign_o;
  logic [ADDR_W-1:0] frm_addr_o;
  logic              frm_long_o;
  logic              rsp_slot_i = 1'b0;
  logic              rsp_ok_i = 1'b0;
  logic              done_o;
  logic              error_o;
  logic [ADDR_W-1:0] dev_count_o;
  logic              discard_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  chain_enum_seq #(.ADDR_W(ADDR_W)) i_chain_enum_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .frm_req_o    (frm_req_o),
    .frm_ack_i    (frm_ack_i),
    .frm_assign_o (frm_assign_o),
    .frm_addr_o   (frm_addr_o),
    .frm_long_o   (frm_long_o),
    .rsp_slot_i   (rsp_slot_i),
    .rsp_ok_i     (rsp_ok_i),
    .done_o       (done_o),
    .error_o      (error_o),
    .dev_count_o  (dev_count_o),
    .discard_o    (discard_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_frames(input int n);
    return (n < TOP) ? n + 2 : TOP + 1;
  endfunction

  function automatic int exp_count(input int n);
    return (n < TOP) ? n : TOP;
  endfunction

  function automatic int exp_addr(input int k);
    return (k <= TOP) ? k : 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_chain(input int n, input bit mid_start);
    int  placed = 0;
    bit  prev   = 1'b0;
    int  k      = 0;
    bit  fin    = 1'b0;
    bit  okv;
    bit  f_as;
    int  f_addr;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(frm_req_o && !done_o && !error_o && frm_long_o, "R2 start", int'(frm_req_o), 1);
    while (!fin && k < 40) begin
      k++;
      while (!frm_req_o) @(negedge clk);
      check(int'(frm_assign_o) == int'(exp_addr(k) != 0), "R2/R8 assign flag", int'(frm_assign_o), int'(exp_addr(k) != 0));
      check(int'(frm_addr_o) == exp_addr(k), "R2/R8 frame address", int'(frm_addr_o), exp_addr(k));
      check(frm_long_o, "R2 long format", int'(frm_long_o), 1);
      for (int d = 0; d < int'($urandom % 3); d++) begin
        rsp_slot_i = 1'($urandom % 2);
        rsp_ok_i   = 1'b1;
        @(negedge clk);
        rsp_slot_i = 1'b0;
        rsp_ok_i   = 1'b0;
      end
      check(frm_req_o, "R3/R10 request held", int'(frm_req_o), 1);
      frm_ack_i = 1'b1;
      f_as   = frm_assign_o;
      f_addr = int'(frm_addr_o);
      @(negedge clk) frm_ack_i = 1'b0;
      check(!frm_req_o, "R3 request dropped", int'(frm_req_o), 0);
      okv = (k == 1) ? 1'($urandom % 2) : prev;
      if (f_as && placed < n) begin
        placed++;
        prev = 1'b1;
      end else begin
        prev = 1'b0;
      end
      if (mid_start && k == 2) begin
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
      end
      repeat ($urandom % 3) @(negedge clk);
      check(!frm_req_o, "R3 no request in flight", int'(frm_req_o), 0);
      rsp_slot_i = 1'b1;
      rsp_ok_i   = okv;
      @(negedge clk);
      rsp_slot_i = 1'b0;
      rsp_ok_i   = 1'b0;
      if (done_o || error_o) fin = 1'b1;
    end
    check(k == exp_frames(n), "R5/R4/R9 frame count", k, exp_frames(n));
    check(int'(dev_count_o) == exp_count(n), "R5 device count", int'(dev_count_o), exp_count(n));
    check(done_o == (n < TOP), "R6 done", int'(done_o), int'(n < TOP));
    check(error_o == (n >= TOP), "R8 error", int'(error_o), int'(n >= TOP));
    if (n < TOP) begin
      check(!frm_long_o, "R6 short format", int'(frm_long_o), 0);
      check(discard_o, "R7 discard raised", int'(discard_o), 1);
      repeat (3) @(negedge clk);
      check(done_o && !frm_req_o, "R6 done held", int'(done_o), 1);
      rsp_slot_i = 1'b1;
      @(negedge clk) rsp_slot_i = 1'b0;
      check(!discard_o, "R7 discard cleared", int'(discard_o), 0);
      check(done_o, "R6 done after slot", int'(done_o), 1);
    end else begin
      repeat (3) @(negedge clk);
      check(!frm_req_o && error_o && !done_o, "R8 stopped in error", int'(frm_req_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!frm_req_o && !done_o && !error_o && !discard_o, "R1 reset flags", int'(frm_req_o), 0);
    check(dev_count_o == '0 && frm_long_o, "R1 reset count/format", int'(dev_count_o), 0);
    run_chain(0, 1'b0);
    run_chain(1, 1'b1);
    run_chain(3, 1'b0);
    run_chain(TOP - 1, 1'b1);
    run_chain(TOP, 1'b0);
    run_chain(TOP + 2, 1'b1);
    for (int r = 0; r < 8; r++) begin
      run_chain(int'($urandom % 20), 1'($urandom % 2));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule